// File: doc/BRIEF.md
# Virtual Machine Branch Resolver

This block settles control flow for a 64-bit register virtual machine. Each accepted instruction brings its program counter (in 64-bit slots), its opcode byte, its source-register field, its 16-bit displacement, its 32-bit immediate and the two 64-bit operand values. One clock later the block returns the following program counter. It also says whether a jump was taken, and whether the instruction was a helper call, a local call or a return.

The opcode byte splits into three fields: bits [2:0] give the class, bit [3] picks the comparison source, and bits [7:4] give the operation. Class 5 compares full 64-bit values. Class 6 compares only the low 32 bits. Every other class is a non-jump instruction that only advances the counter. The call stack, helper dispatch and the fetch of the second slot of wide instructions all live outside the block. The block supplies what they need: the return slot, the helper number and a return request.

Top module: `jump_resolve`

## Requirements
- R1: While rst_n is low, and on the first clock after it rises with no input, out_valid, taken, helper_call, local_call and exit_req are 0.
- R2: A class other than 5 or 6 (opcode[2:0]) gives next_pc = pc+1, or pc+2 when wide is 1, with taken 0.
- R3: In class 5 the conditional operations (opcode[7:4]) are 1 equal, 5 not equal, 2 unsigned greater, 3 unsigned greater-or-equal, 10 unsigned less and 11 unsigned less-or-equal. When opcode[3]=1 they compare dst_val with src_val. When opcode[3]=0 they compare dst_val with imm sign-extended to 64 bits. If the condition holds, next_pc = pc+1+offset (signed) and taken is 1. Otherwise next_pc = pc+1.
- R4: Operations 6, 7, 12 and 13 are the signed greater, greater-or-equal, less and less-or-equal forms of the comparisons in R3.
- R5: In class 6 the comparisons use only bits [31:0] of both values. When opcode[3]=0 the other value is imm itself.
- R6: Operation 4 is taken when the AND of the two values is nonzero.
- R7: Operation 0 is always taken. Class 5 jumps to pc+1+offset. Class 6 jumps to pc+1+imm (signed).
- R8: Operation 8 in class 5 with src_reg 1 sets local_call and taken, gives next_pc = pc+1+imm, and puts pc+1 on ret_pc.
- R9: Operation 8 in class 5 with src_reg 0 or 2 sets helper_call, puts imm on helper_id, keeps next_pc = pc, and leaves taken at 0.
- R10: Operation 9 in class 5 sets exit_req with taken 0 and next_pc = pc+1.
- R11: Operations 8 and 9 in class 6, operation 8 with any other src_reg, and operations 14 and 15 produce no call, exit or jump, and next_pc = pc+1.
- R12: Results appear one clock after in_valid. A cycle without in_valid gives out_valid 0, and all four flags are 0 in that cycle.
- R13: All program counter arithmetic wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| pc | input | PC_W | Current slot number |
| opcode | input | 8 | Operation, source select, class |
| src_reg | input | 4 | Source register field |
| offset | input | 16 | Signed displacement |
| imm | input | 32 | Immediate |
| dst_val | input | 64 | Destination operand value |
| src_val | input | 64 | Source operand value |
| wide | input | 1 | Instruction occupies two slots |
| out_valid | output | 1 | Result valid |
| next_pc | output | PC_W | Following slot number |
| taken | output | 1 | Redirect taken |
| helper_call | output | 1 | Helper call request |
| helper_id | output | 32 | Helper number |
| local_call | output | 1 | Local call request |
| ret_pc | output | PC_W | Return slot for a local call |
| exit_req | output | 1 | Return request |

## Verification
A local call is the one case where a redirect and a stack push happen in the same cycle. taken, the new next_pc and ret_pc must all be right together. The bench provokes this with negative and wrapping immediates, and judges every field of that cycle against its model. A helper call is the opposite case: a request with no redirect and a held counter. Random streams then mix all classes with back-to-back and idle cycles, and every clock is compared.

// File: rtl/jump_resolve.sv
module jump_resolve #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PC_W-1:0] pc,
  input  logic [7:0]      opcode,
  input  logic [3:0]      src_reg,
  input  logic [15:0]     offset,
  input  logic [31:0]     imm,
  input  logic [63:0]     dst_val,
  input  logic [63:0]     src_val,
  input  logic            wide,
  output logic            out_valid,
  output logic [PC_W-1:0] next_pc,
  output logic            taken,
  output logic            helper_call,
  output logic [31:0]     helper_id,
  output logic            local_call,
  output logic [PC_W-1:0] ret_pc,
  output logic            exit_req
);
  localparam logic [2:0] CLS_J64 = 3'd5;
  localparam logic [2:0] CLS_J32 = 3'd6;

  logic [2:0] cls;
  logic [3:0] op;
  logic       use_reg, is64, is32;
  assign cls     = opcode[2:0];
  assign use_reg = opcode[3];
  assign op      = opcode[7:4];
  assign is64    = (cls == CLS_J64);
  assign is32    = (cls == CLS_J32);

  logic [63:0] rhs64, ua, ub, sa, sb;
  assign rhs64 = use_reg ? src_val : {{32{imm[31]}}, imm};
  assign ua = is32 ? {32'd0, dst_val[31:0]} : dst_val;
  assign ub = is32 ? {32'd0, rhs64[31:0]}   : rhs64;
  assign sa = is32 ? {{32{dst_val[31]}}, dst_val[31:0]} : dst_val;
  assign sb = is32 ? {{32{rhs64[31]}}, rhs64[31:0]}     : rhs64;

  logic eq, ltu, lts, anyset;
  assign eq     = (ua == ub);
  assign ltu    = (ua < ub);
  assign lts    = ($signed(sa) < $signed(sb));
  assign anyset = |(ua & ub);

  logic cond;
  always_comb begin
    case (op)
      4'h1:    cond = eq;
      4'h2:    cond = !ltu && !eq;
      4'h3:    cond = !ltu;
      4'h4:    cond = anyset;
      4'h5:    cond = !eq;
      4'h6:    cond = !lts && !eq;
      4'h7:    cond = !lts;
      4'ha:    cond = ltu;
      4'hb:    cond = ltu || eq;
      4'hc:    cond = lts;
      4'hd:    cond = lts || eq;
      default: cond = 1'b0;
    endcase
  end

  logic [PC_W-1:0] seq, off_x, imm_x;
  assign seq   = pc + PC_W'(1);
  assign off_x = PC_W'($signed(offset));
  assign imm_x = PC_W'($signed(imm));

  logic [PC_W-1:0] nxt;
  logic tk, hc, lc, ex;
  always_comb begin
    nxt = seq;
    tk = 1'b0; hc = 1'b0; lc = 1'b0; ex = 1'b0;
    if (!is64 && !is32) begin
      if (wide) nxt = pc + PC_W'(2);
    end else begin
      case (op)
        4'h0: begin
          tk  = 1'b1;
          nxt = seq + (is64 ? off_x : imm_x);
        end
        4'h8: if (is64) begin
          if (src_reg == 4'd1) begin
            tk = 1'b1; lc = 1'b1; nxt = seq + imm_x;
          end else if (src_reg == 4'd0 || src_reg == 4'd2) begin
            hc = 1'b1; nxt = pc;
          end
        end
        4'h9: ex = is64;
        4'he, 4'hf: ;
        default: if (cond) begin
          tk = 1'b1; nxt = seq + off_x;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      next_pc     <= '0;
      taken       <= 1'b0;
      helper_call <= 1'b0;
      helper_id   <= '0;
      local_call  <= 1'b0;
      ret_pc      <= '0;
      exit_req    <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      taken       <= in_valid && tk;
      helper_call <= in_valid && hc;
      local_call  <= in_valid && lc;
      exit_req    <= in_valid && ex;
      if (in_valid) begin
        next_pc   <= nxt;
        helper_id <= imm;
        ret_pc    <= seq;
      end
    end
  end
endmodule

module jump_resolve_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [PC_W-1:0] pc,
  input logic            out_valid,
  input logic [PC_W-1:0] next_pc,
  input logic            taken,
  input logic            helper_call,
  input logic            local_call,
  input logic [PC_W-1:0] ret_pc,
  input logic            exit_req
);
  // R12
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(taken || helper_call || local_call || exit_req));
  // R12
  valid_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R9
  helper_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    helper_call |-> (next_pc == $past(pc)) && !taken);
  // R8
  local_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_call |-> taken && (ret_pc == PC_W'($past(pc) + PC_W'(1))));
  // R10
  exit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> !taken && (next_pc == PC_W'($past(pc) + PC_W'(1))));
  // R11
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({helper_call, local_call, exit_req}));
  // R2
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !taken && !helper_call |->
      (next_pc == PC_W'($past(pc) + PC_W'(1))) || (next_pc == PC_W'($past(pc) + PC_W'(2))));
endmodule

bind jump_resolve jump_resolve_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/jump_resolve_bench.sv
module jump_resolve_bench;
  localparam int PC_W = 32;

  logic clk = 0, rst_n = 0, in_valid = 0, wide = 0;
  logic [PC_W-1:0] pc = 0;
  logic [7:0] opcode = 0;
  logic [3:0] src_reg = 0;
  logic [15:0] offset = 0;
  logic [31:0] imm = 0;
  logic [63:0] dst_val = 0, src_val = 0;
  logic out_valid, taken, helper_call, local_call, exit_req;
  logic [PC_W-1:0] next_pc, ret_pc;
  logic [31:0] helper_id;

  jump_resolve #(.PC_W(PC_W)) u_jump_resolve (.*);

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic [PC_W-1:0] e_nx, e_ret;
  logic e_tk, e_hc, e_lc, e_ex;
  logic [31:0] e_id;

  task automatic model(input logic [31:0] p, input logic [7:0] op, input logic [3:0] sr,
                       input logic [15:0] off, input logic [31:0] im,
                       input logic [63:0] d, input logic [63:0] s, input logic w);
    int c, cl;
    longint unsigned ud, us;
    longint sd, ss;
    bit cnd;
    logic [31:0] offx, immx;
    c = int'(op[7:4]); cl = int'(op[2:0]);
    offx = {{16{off[15]}}, off}; immx = im;
    e_tk = 0; e_hc = 0; e_lc = 0; e_ex = 0; e_id = im; e_ret = p + 1;
    e_nx = p + 1;
    if (cl != 5 && cl != 6) begin
      if (w) e_nx = p + 2;
      return;
    end
    if (cl == 5) begin
      ud = d;
      us = op[3] ? s : {{32{im[31]}}, im};
      sd = longint'(ud); ss = longint'(us);
    end else begin
      ud = {32'd0, d[31:0]};
      us = op[3] ? {32'd0, s[31:0]} : {32'd0, im};
      sd = longint'(int'(d[31:0]));
      ss = longint'(int'(us[31:0]));
    end
    cnd = 0;
    case (c)
      1: cnd = ud == us;   2: cnd = ud > us;   3: cnd = ud >= us;
      4: cnd = (ud & us) != 0;  5: cnd = ud != us;
      6: cnd = sd > ss;    7: cnd = sd >= ss;
      10: cnd = ud < us;   11: cnd = ud <= us;
      12: cnd = sd < ss;   13: cnd = sd <= ss;
      default: cnd = 0;
    endcase
    if (c == 0) begin
      e_tk = 1; e_nx = p + 1 + (cl == 5 ? offx : immx);
    end else if (c == 8) begin
      if (cl == 5 && sr == 1) begin e_tk = 1; e_lc = 1; e_nx = p + 1 + immx; end
      else if (cl == 5 && (sr == 0 || sr == 2)) begin e_hc = 1; e_nx = p; end
    end else if (c == 9) begin
      e_ex = (cl == 5);
    end else if (cnd) begin
      e_tk = 1; e_nx = p + 1 + offx;
    end
  endtask

  task automatic check(input string tag, input logic valid_exp);
    bit bad;
    n_run++;
    if (!valid_exp)
      bad = out_valid || taken || helper_call || local_call || exit_req;
    else
      bad = !out_valid || next_pc !== e_nx || taken !== e_tk || helper_call !== e_hc ||
            local_call !== e_lc || exit_req !== e_ex ||
            (e_hc && helper_id !== e_id) || (e_lc && ret_pc !== e_ret);
    if (bad) begin
      n_fail++;
      $display("FAIL %s: got v=%0b nx=%h tk=%0b hc=%0b id=%h lc=%0b ret=%h ex=%0b exp nx=%h tk=%0b hc=%0b id=%h lc=%0b ret=%h ex=%0b",
               tag, out_valid, next_pc, taken, helper_call, helper_id, local_call, ret_pc, exit_req,
               e_nx, e_tk, e_hc, e_id, e_lc, e_ret, e_ex);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] p, input logic [7:0] op,
                     input logic [3:0] sr, input logic [15:0] off, input logic [31:0] im,
                     input logic [63:0] d, input logic [63:0] s, input logic w);
    @(negedge clk);
    in_valid = 1; pc = p; opcode = op; src_reg = sr; offset = off; imm = im;
    dst_val = d; src_val = s; wide = w;
    model(p, op, sr, off, im, d, s, w);
    @(negedge clk);
    in_valid = 0;
    check(tag, 1'b1);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    check(tag, 1'b0);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 1'b0);

    run("R2 plain step", 32'h100, 8'h07, 0, 0, 0, 0, 0, 0);
    run("R2 wide step", 32'h100, 8'h18, 0, 0, 0, 0, 0, 1);
    run("R13 wrap", 32'hFFFF_FFFF, 8'h61, 0, 0, 0, 0, 0, 0);
    run("R13 wide wrap", 32'hFFFF_FFFF, 8'h18, 0, 0, 0, 0, 0, 1);
    run("R3 jeq reg taken", 32'h40, 8'h1d, 0, 16'hFFF0, 0, 64'h5, 64'h5, 0);
    run("R3 jeq sext imm", 32'h40, 8'h15, 0, 16'd7, 32'hFFFF_FFFF, '1, 0, 0);
    run("R3 jgt unsigned", 32'h40, 8'h2d, 0, 16'd3, 0, '1, 64'd1, 0);
    run("R3 jle not taken", 32'h40, 8'hbd, 0, 16'd3, 0, 64'd9, 64'd8, 0);
    run("R3 jne wide ignored", 32'h40, 8'h5d, 0, 16'd3, 0, 64'd9, 64'd9, 1);
    run("R4 jsgt signed", 32'h40, 8'h6d, 0, 16'd3, 0, '1, 64'd1, 0);
    run("R4 jslt signed", 32'h40, 8'hcd, 0, 16'hFFFE, 0, '1, 64'd1, 0);
    run("R4 jsge equal", 32'h40, 8'h75, 0, 16'd2, 32'h8000_0000, 64'hFFFF_FFFF_8000_0000, 0, 0);
    run("R5 low halves eq", 32'h40, 8'h1e, 0, 16'd4, 0, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 0);
    run("R5 jslt32", 32'h40, 8'hc6, 0, 16'd4, 32'd0, 64'h0000_0000_8000_0000, 0, 0);
    run("R5 jlt32 unsigned", 32'h40, 8'ha6, 0, 16'd4, 32'd0, 64'h0000_0000_8000_0000, 0, 0);
    run("R6 jset zero", 32'h40, 8'h4d, 0, 16'd4, 0, 64'hF0, 64'h0F, 0);
    run("R6 jset hit", 32'h40, 8'h45, 0, 16'd4, 32'h8000_0000, 64'h8000_0000_0000_0000, 0, 0);
    run("R7 ja offset", 32'h40, 8'h05, 0, 16'hFFC0, 32'h1234, 0, 0, 0);
    run("R7 ja imm", 32'h40, 8'h06, 0, 16'h0010, 32'hFFFF_FFF0, 0, 0, 0);
    run("R8 local call", 32'h200, 8'h85, 1, 0, 32'hFFFF_FF00, 0, 0, 0);
    run("R8 local call wrap", 32'hFFFF_FFFF, 8'h85, 1, 0, 32'd5, 0, 0, 0);
    run("R9 helper static", 32'h300, 8'h85, 0, 0, 32'd77, 0, 0, 0);
    run("R9 helper type", 32'h300, 8'h85, 2, 0, 32'hDEAD_BEEF, 0, 0, 0);
    run("R10 exit", 32'h300, 8'h95, 0, 0, 0, 0, 0, 0);
    run("R11 call class6", 32'h300, 8'h86, 1, 0, 32'd9, 0, 0, 0);
    run("R11 exit class6", 32'h300, 8'h96, 0, 0, 0, 0, 0, 0);
    run("R11 call src3", 32'h300, 8'h85, 3, 0, 32'd9, 0, 0, 0);
    run("R11 code e", 32'h300, 8'he5, 0, 16'd9, 0, 0, 0, 0);
    idle("R12 idle");

    // R12 back-to-back random stream compared every clock
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] op;
      op = $urandom;
      if (i % 3 != 0) op[2:1] = (op[0] ? 2'b10 : 2'b11) ^ 2'b01;
      @(negedge clk);
      if (i > 0) check(in_valid ? "R12 stream" : "R12 stream idle", in_valid);
      in_valid = ($urandom % 8) != 0;
      pc = $urandom; opcode = op; src_reg = $urandom % 4; offset = $urandom;
      imm = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      dst_val = {$urandom, $urandom};
      src_val = ($urandom % 3 == 0) ? dst_val : {$urandom, $urandom};
      wide = $urandom;
      model(pc, opcode, src_reg, offset, imm, dst_val, src_val, wide);
    end
    @(negedge clk);
    check("R12 stream last", in_valid);
    in_valid = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule